// File: doc/BRIEF.md
# Prioritized UART Interrupt Identifier

This block gathers the interrupt sources of a UART into one interrupt line and one identification byte. Five conditions are tracked: a receive error event, received data at or above a trigger level, an idle-receiver timeout, an empty transmit holding register, and a modem line change. A fixed priority decides which of them the identification byte reports. The CPU reads that byte to find out why the line is high, then services the source it names.

In FIFO mode the received-data condition compares the receive FIFO fill count against a programmable threshold. A timer runs on the 16x baud enable and raises a timeout when bytes have been waiting for four character times with no traffic. Outside FIFO mode any byte held counts as received data, and the timeout is off. The identification byte is registered. It holds still for as long as the CPU read strobe for it is high.

All inputs and outputs are plain control and status pins. There is no streaming interface and no back-pressure. Strobes and events are single-cycle or level signals in the `clk` domain.

Top module: `uart_irq_id`

## Requirements
- R1: When several enabled sources are pending, the reported source follows this order, highest first: line error, received data, timeout, transmit empty, modem change.
- R2: Identification low nibble codes are 0110 for line error, 0100 for received data, 1100 for timeout, 0010 for transmit empty, 0000 for modem change, and 0001 when no enabled source is pending.
- R3: Identification bits 7:6 are 11 when `fifo_mode` is 1 and 00 otherwise. Bits 5:4 are always 0.
- R4: In FIFO mode, received data is pending while `rx_count` is at least the level chosen by `trig_sel` (00→1, 01→4, 10→8, 11→14), and stops being pending as soon as the count is below it. Outside FIFO mode it is pending while `rx_count` is nonzero.
- R5: In FIFO mode with `rx_count` nonzero, the timeout becomes pending after 4×T ticks of `tick16` with no received character and no FIFO read. T is 16×(1 + data bits + parity bit) plus the stop time: 16 ticks for one stop bit, and 24 or 32 ticks when `stop2` is 1 (24 with 5 data bits). Data bits are 5 + `wlen`.
- R6: A `rx_char` pulse or an `rd_rbr` strobe restarts the timeout count. An `rd_rbr` strobe also clears a pending timeout.
- R7: `ier_en` bits 0, 1, 2 and 3 gate received data/timeout, transmit empty, line error and modem change respectively. A disabled source neither raises `irq` nor is reported.
- R8: Transmit empty becomes pending on a 0→1 change of `tx_empty`, including the first cycle after reset. It clears on `wr_thr`, or on an `rd_iir` cycle while the identification byte reports transmit empty.
- R9: Line error becomes pending on an `err_evt` pulse and clears on `rd_lsr`. Modem change becomes pending when any bit of `modem_chg` is high and clears on `rd_msr`. If an event and its clear arrive in the same cycle, the event wins.
- R10: While `rd_iir` stays high, `iid` does not change. Events that arrive during the read are still recorded and show up afterwards.
- R11: `irq` is high whenever an enabled source is pending and is low in reset. `iid` reflects the pending state one clock after it changes, and reads 0x01 after reset while no source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | 16x baud enable |
| ier_en | input | 4 | Source enables |
| fifo_mode | input | 1 | FIFO mode enable |
| trig_sel | input | 2 | Receive trigger level select |
| rx_count | input | CNT_W | Receive FIFO fill count |
| wlen | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity bit present |
| stop2 | input | 1 | Long stop time |
| rx_char | input | 1 | Pulse: character received |
| err_evt | input | 1 | Pulse: receive error event |
| tx_empty | input | 1 | Transmit holding register empty |
| modem_chg | input | 4 | Modem change flags |
| rd_rbr | input | 1 | CPU reads receive data |
| rd_iir | input | 1 | CPU reads identification byte |
| rd_lsr | input | 1 | CPU reads line status |
| rd_msr | input | 1 | CPU reads modem status |
| wr_thr | input | 1 | CPU writes transmit data |
| irq | output | 1 | Interrupt line |
| iid | output | 8 | Identification byte |

## Verification
Several properties are checked on every cycle. The identification byte holds during a held read. A timeout only appears after a cycle with no restart. An empty FIFO suppresses the timeout. An enabled line error forces the interrupt line high. A transmit write without a new empty event clears transmit empty. The bench scenarios are needed for the rest. They cover the exact code for each trigger level and count, the priority walk as sources are serviced one by one, and the timeout firing on the exact tick for a given framing. They also cover what happens after a read ends: a transmit-empty source that was reported is cleared, and an event that arrived during the read becomes visible.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam logic [3:0] CODE_LINE = 4'b0110;
  localparam logic [3:0] CODE_RXD  = 4'b0100;
  localparam logic [3:0] CODE_TMO  = 4'b1100;
  localparam logic [3:0] CODE_THRE = 4'b0010;
  localparam logic [3:0] CODE_MDM  = 4'b0000;
  localparam logic [3:0] CODE_NONE = 4'b0001;

  localparam int TICKS_PER_BIT = 16;
  localparam int TMO_CHARS     = 4;

  typedef struct packed {
    logic line;
    logic rxd;
    logic tmo;
    logic thre;
    logic mdm;
  } irq_src_t;

  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   trig_level = 5'd1;
      2'b01:   trig_level = 5'd4;
      2'b10:   trig_level = 5'd8;
      default: trig_level = 5'd14;
    endcase
  endfunction
endpackage

// File: rtl/irq_rx_level.sv
module irq_rx_level
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             fifo_mode,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] rx_count,
  output logic             rx_data
);
  logic [CNT_W-1:0] level;

  always_comb begin
    level = CNT_W'(trig_level(trig_sel));
    if (fifo_mode) rx_data = (rx_count >= level);
    else           rx_data = (rx_count != '0);
  end
endmodule

// File: rtl/irq_char_timer.sv
module irq_char_timer
  import uart_irq_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int MAX_BITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick16,
  input  logic             fifo_mode,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [1:0]       wlen,
  input  logic             par_en,
  input  logic             stop2,
  input  logic             rx_char,
  input  logic             rd_rbr,
  output logic             to_pend
);
  localparam int LIM_MAX = TMO_CHARS * TICKS_PER_BIT * MAX_BITS;
  localparam int TMR_W   = $clog2(LIM_MAX + 1);

  logic [TMR_W-1:0] cnt;
  logic [TMR_W-1:0] frame_ticks;
  logic [TMR_W-1:0] limit;
  logic             empty;

  always_comb begin
    frame_ticks = TMR_W'(TICKS_PER_BIT * (6 + int'(wlen) + int'(par_en)));
    if (!stop2)             frame_ticks = frame_ticks + TMR_W'(TICKS_PER_BIT);
    else if (wlen == 2'b00) frame_ticks = frame_ticks + TMR_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
    else                    frame_ticks = frame_ticks + TMR_W'(2 * TICKS_PER_BIT);
    limit = TMR_W'(TMO_CHARS) * frame_ticks;
    empty = (rx_count == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      to_pend <= 1'b0;
    end else if (!fifo_mode || empty) begin
      cnt     <= '0;
      to_pend <= 1'b0;
    end else if (rx_char || rd_rbr) begin
      cnt <= '0;
      if (rd_rbr) to_pend <= 1'b0;
    end else if (tick16 && !to_pend) begin
      if (cnt == limit - 1'b1) to_pend <= 1'b1;
      else                     cnt     <= cnt + 1'b1;
    end
  end

  AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> !to_pend); // R5
  AST_TMO_QUIET_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_pend) |-> $past(!rx_char && !rd_rbr)); // R6
endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ier_en,
  input  logic       fifo_mode,
  input  irq_src_t   src,
  input  logic       rd_iir,
  output logic       irq,
  output logic [7:0] iid
);
  logic [3:0] code;
  logic [7:0] live;
  logic [7:0] iid_q;

  always_comb begin
    if (ier_en[2] && src.line)                  code = CODE_LINE;
    else if (ier_en[0] && src.rxd)              code = CODE_RXD;
    else if (ier_en[0] && src.tmo && fifo_mode) code = CODE_TMO;
    else if (ier_en[1] && src.thre)             code = CODE_THRE;
    else if (ier_en[3] && src.mdm)              code = CODE_MDM;
    else                                        code = CODE_NONE;
    live = {fifo_mode ? 2'b11 : 2'b00, 2'b00, fifo_mode ? code[3] : 1'b0, code[2:0]};
    irq  = (ier_en[2] & src.line) | (ier_en[0] & (src.rxd | src.tmo)) |
           (ier_en[1] & src.thre) | (ier_en[3] & src.mdm);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       iid_q <= {4'b0000, CODE_NONE};
    else if (!rd_iir) iid_q <= live;
  end

  assign iid = iid_q;

  AST_IID_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iir && $past(rd_iir)) |-> $stable(iid_q)); // R10
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick16,
  input  logic [3:0]       ier_en,
  input  logic             fifo_mode,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [1:0]       wlen,
  input  logic             par_en,
  input  logic             stop2,
  input  logic             rx_char,
  input  logic             err_evt,
  input  logic             tx_empty,
  input  logic [3:0]       modem_chg,
  input  logic             rd_rbr,
  input  logic             rd_iir,
  input  logic             rd_lsr,
  input  logic             rd_msr,
  input  logic             wr_thr,
  output logic             irq,
  output logic [7:0]       iid
);
  logic     line_pend, thre_pend, mdm_pend, tx_prev;
  logic     thre_set, thre_reported;
  logic     rx_data, to_pend;
  irq_src_t src;

  irq_rx_level #(.CNT_W(CNT_W)) u_lvl (
    .fifo_mode(fifo_mode), .trig_sel(trig_sel), .rx_count(rx_count), .rx_data(rx_data)
  );

  irq_char_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .fifo_mode(fifo_mode),
    .rx_count(rx_count), .wlen(wlen), .par_en(par_en), .stop2(stop2),
    .rx_char(rx_char), .rd_rbr(rd_rbr), .to_pend(to_pend)
  );

  assign thre_set      = tx_empty && !tx_prev;
  assign thre_reported = (iid[3:0] == CODE_THRE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_pend <= 1'b0;
      thre_pend <= 1'b0;
      mdm_pend  <= 1'b0;
      tx_prev   <= 1'b0;
    end else begin
      tx_prev <= tx_empty;
      if (err_evt)     line_pend <= 1'b1;
      else if (rd_lsr) line_pend <= 1'b0;
      if (|modem_chg)  mdm_pend  <= 1'b1;
      else if (rd_msr) mdm_pend  <= 1'b0;
      if (thre_set)                           thre_pend <= 1'b1;
      else if (wr_thr || (rd_iir && thre_reported)) thre_pend <= 1'b0;
    end
  end

  always_comb begin
    src.line = line_pend;
    src.rxd  = rx_data;
    src.tmo  = to_pend;
    src.thre = thre_pend;
    src.mdm  = mdm_pend;
  end

  irq_prio u_prio (
    .clk(clk), .rst_n(rst_n), .ier_en(ier_en), .fifo_mode(fifo_mode),
    .src(src), .rd_iir(rd_iir), .irq(irq), .iid(iid)
  );

  AST_LINE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_en[2] && line_pend) |-> irq); // R7
  AST_THR_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_thr && !thre_set) |=> !thre_pend); // R8
endmodule

// File: tb/sim_uart_irq_id.sv
module sim_uart_irq_id;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic [3:0] ier_en = '0;
  logic       fifo_mode = 1'b0;
  logic [1:0] trig_sel = '0;
  logic [4:0] rx_count = '0;
  logic [1:0] wlen = '0;
  logic       par_en = 1'b0;
  logic       stop2 = 1'b0;
  logic       rx_char = 1'b0;
  logic       err_evt = 1'b0;
  logic       tx_empty = 1'b0;
  logic [3:0] modem_chg = '0;
  logic       rd_rbr = 1'b0, rd_iir = 1'b0, rd_lsr = 1'b0, rd_msr = 1'b0, wr_thr = 1'b0;
  logic       irq;
  logic [7:0] iid;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  uart_irq_id u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .ier_en(ier_en), .fifo_mode(fifo_mode),
    .trig_sel(trig_sel), .rx_count(rx_count), .wlen(wlen), .par_en(par_en), .stop2(stop2),
    .rx_char(rx_char), .err_evt(err_evt), .tx_empty(tx_empty), .modem_chg(modem_chg),
    .rd_rbr(rd_rbr), .rd_iir(rd_iir), .rd_lsr(rd_lsr), .rd_msr(rd_msr), .wr_thr(wr_thr),
    .irq(irq), .iid(iid)
  );

  // vector: {fifo, trig[1:0], count[4:0], ier[3:0], nibble[3:0]}
  localparam int NV = 11;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 2'b00, 5'd0,  4'b0001, 4'b0001},
    {1'b0, 2'b11, 5'd1,  4'b0001, 4'b0100},
    {1'b1, 2'b00, 5'd1,  4'b0001, 4'b0100},
    {1'b1, 2'b01, 5'd3,  4'b0001, 4'b0001},
    {1'b1, 2'b01, 5'd4,  4'b0001, 4'b0100},
    {1'b1, 2'b10, 5'd7,  4'b0001, 4'b0001},
    {1'b1, 2'b10, 5'd8,  4'b0001, 4'b0100},
    {1'b1, 2'b11, 5'd13, 4'b0001, 4'b0001},
    {1'b1, 2'b11, 5'd14, 4'b0001, 4'b0100},
    {1'b1, 2'b11, 5'd16, 4'b0000, 4'b0001},
    {1'b1, 2'b10, 5'd9,  4'b1110, 4'b0001}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int tmo_lim(input int wl, input int par, input int st2);
    int fr;
    fr = 16 * (1 + 5 + wl + par);
    if (st2 == 0)      fr += 16;
    else if (wl == 0)  fr += 24;
    else               fr += 32;
    return 4 * fr;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lim;
    repeat (3) @(negedge clk);
    chk("R11 reset irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    step();
    chk("R11 reset iid", iid, 8'h01);

    // table walk: trigger levels, mode bits, enables (R4 R3 R7 R2)
    for (int i = 0; i < NV; i++) begin
      fifo_mode = VEC[i][15];
      trig_sel  = VEC[i][14:13];
      rx_count  = VEC[i][12:8];
      ier_en    = VEC[i][7:4];
      step();
      chk("R4 vector irq", {7'd0, irq}, {7'd0, VEC[i][3:0] != 4'b0001});
      chk("R3 vector iid", iid, {VEC[i][15] ? 2'b11 : 2'b00, 2'b00, VEC[i][3:0]});
    end

    // priority walk (R1 R9 R8)
    fifo_mode = 1'b0; rx_count = 5'd0; ier_en = 4'b1111;
    step();
    err_evt = 1'b1; modem_chg = 4'b0100; tx_empty = 1'b1; rx_count = 5'd1;
    step();
    err_evt = 1'b0; modem_chg = 4'b0000;
    step();
    chk("R1 line first", iid, 8'h06);
    rd_lsr = 1'b1; step(); rd_lsr = 1'b0; step();
    chk("R1 rx data next", iid, 8'h04);
    rx_count = 5'd0; step(); step();
    chk("R1 thre next", iid, 8'h02);
    wr_thr = 1'b1; step(); wr_thr = 1'b0; step();
    chk("R8 thr write clears, R1 modem", iid, 8'h00);
    rd_msr = 1'b1; step(); rd_msr = 1'b0; step();
    chk("R9 msr read clears", iid, 8'h01);
    chk("R11 irq low", {7'd0, irq}, 8'h00);

    // frozen read and THRE clear on reported read (R10 R8)
    tx_empty = 1'b0; step();
    tx_empty = 1'b1; step(); step();
    chk("R8 thre on rise", iid, 8'h02);
    rd_iir = 1'b1; step();
    err_evt = 1'b1; step(); err_evt = 1'b0; step();
    chk("R10 frozen during read", iid, 8'h02);
    chk("R9 event recorded", {7'd0, irq}, 8'h01);
    rd_iir = 1'b0; step();
    chk("R10 new event after read", iid, 8'h06);
    rd_lsr = 1'b1; step(); rd_lsr = 1'b0; step();
    chk("R8 thre cleared by id read", iid, 8'h01);

    // enable gating of modem source (R7)
    ier_en = 4'b0111; modem_chg = 4'b0001; step(); modem_chg = 4'b0000; step();
    chk("R7 modem disabled", {7'd0, irq}, 8'h00);
    ier_en = 4'b1111; step();
    chk("R7 modem enabled", iid, 8'h00);
    rd_msr = 1'b1; step(); rd_msr = 1'b0;

    // timeout, 5N1 (R5)
    fifo_mode = 1'b1; trig_sel = 2'b01; rx_count = 5'd1; ier_en = 4'b0001;
    wlen = 2'b00; par_en = 1'b0; stop2 = 1'b0;
    lim = tmo_lim(0, 0, 0);
    rx_char = 1'b1; step();
    rx_char = 1'b0; tick16 = 1'b1;
    repeat (lim - 1) @(posedge clk);
    @(negedge clk);
    chk("R5 not yet at limit-1", {7'd0, irq}, 8'h00);
    step();
    chk("R5 timeout irq", {7'd0, irq}, 8'h01);
    step();
    chk("R5 timeout code", iid, 8'hCC);
    tick16 = 1'b0; rd_rbr = 1'b1; step(); rd_rbr = 1'b0; step();
    chk("R6 read clears timeout", iid, 8'hC1);

    // restart by FIFO read, 8 bits parity long stop (R6 R5)
    wlen = 2'b11; par_en = 1'b1; stop2 = 1'b1;
    lim = tmo_lim(3, 1, 1);
    rx_char = 1'b1; step();
    rx_char = 1'b0; tick16 = 1'b1;
    repeat (lim - 3) @(posedge clk);
    @(negedge clk);
    tick16 = 1'b0; rd_rbr = 1'b1; step();
    rd_rbr = 1'b0; tick16 = 1'b1;
    repeat (lim - 1) @(posedge clk);
    @(negedge clk);
    chk("R6 restart after read", {7'd0, irq}, 8'h00);
    step();
    chk("R5 timeout 8E2", {7'd0, irq}, 8'h01);
    tick16 = 1'b0;
    rx_count = 5'd0; step(); step();
    chk("R5 empty clears timeout", iid, 8'hC1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule